// File: doc/BRIEF.md
# Halt Mode Wake-Up Sequencer

This block governs how a small processor core enters and leaves a low-power halt state. Software writes the halt request, and the sequencer then gates off the core clock, the timers, the watchdog and the oscillator. If the clock monitor is enabled, it keeps the watchdog output pin driven low for as long as the core is halted.

Two events end the halt. The first is a rising edge on an enabled wake input. It restarts only the oscillator. A stabilisation counter then runs for a fixed number of instruction-clock ticks, where one tick is the oscillator clock divided by a fixed ratio. When that count has run out, the core clock comes back and execution resumes where it stopped. The second event is the external reset pin going low. It takes priority over everything else, forces a full reset, and lets execution restart from address zero once the pin is released.

All timing is counted in cycles of the free-running oscillator clock `clk`. Both asynchronous pins pass through two-flop synchronisers. Every output is registered, so each output changes on the same edge as the state register.

Top module: `halt_wake_seq`

## Requirements
- R1: After `rst`, the block is in the running state: `core_clk_en`, `osc_en`, `timer_en` and `wdog_en` are 1, and `halt_flag`, `reset_out`, `resume_pulse` and `wdout_low` are 0.
- R2: When `halt_set` is 1 at a clock edge while running, the outputs change on that same edge: `core_clk_en`, `timer_en`, `wdog_en` and `osc_en` go to 0 and `halt_flag` goes to 1.
- R3: `wdout_low` equals `clkmon_en` while the core is halted with the oscillator stopped. In every other state it is 0.
- R4: A rising edge on `wake_in[i]` with `wake_en[i]`=1 during halt sets `osc_en` to 1 on the third clock edge after the input changes. At that point `core_clk_en` stays 0 and `halt_flag` stays 1.
- R5: Exactly STAB_COUNT×OSC_DIV cycles after `osc_en` rises, `core_clk_en` returns to 1 and `halt_flag` clears. `resume_pulse` is 1 for that single cycle. With the defaults of 256 and 9 this is 2304 cycles.
- R6: A wake edge has no effect if its `wake_en` bit is 0 or if it arrives while the core is running. An edge seen while running is not remembered for a later halt.
- R7: When `ext_rst_n` is low, `reset_out` goes to 1 on the third edge, from any state. During reset `core_clk_en` is 0, `osc_en` is 1 and `halt_flag` is 0. Three edges after the pin is released, the block runs again with `reset_out` 0 and no `resume_pulse`.
- R8: A reset that arrives during the stabilisation delay wins over the delay. The core restarts through the reset path and no resume pulse is ever issued for the abandoned wake-up.
- R9: `halt_set` has no effect outside the running state. In particular, it does not restart the stabilisation count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, free-running |
| rst | input | 1 | Synchronous active-high reset of the block |
| halt_set | input | 1 | Software write of 1 to the halt request |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| clkmon_en | input | 1 | Clock monitor enable |
| wake_en | input | WAKE_W | Per-input wake enable |
| wake_in | input | WAKE_W | Wake inputs, asynchronous, rising edge |
| core_clk_en | output | 1 | Core clock enable |
| osc_en | output | 1 | Oscillator enable |
| timer_en | output | 1 | Timer clock enable |
| wdog_en | output | 1 | Watchdog logic enable |
| wdout_low | output | 1 | Clock monitor drives the watchdog pin low |
| halt_flag | output | 1 | Halt request flag, readable state |
| reset_out | output | 1 | Full reset applied to the core |
| resume_pulse | output | 1 | One-cycle pulse: execution resumes at the halt point |

## Verification
The bench counts the wake-up delay edge by edge. A divider or counter that is off by one shifts `resume_pulse` by a single cycle, or by nine cycles, and the scoreboard flags the shift.

It also aims at the cases where an event must not change anything:
- a wake edge on a masked input;
- a wake edge that arrives while the core is running, which a sticky edge detector would replay at the next halt;
- a halt write made during the delay, which a careless design would use to reload the count.

Finally, it pulls reset in the middle of the delay. A design that lets the delay finish anyway would emit a resume pulse that the scoreboard never expects.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HALT  = 2'd1,
    ST_OSC   = 2'd2,
    ST_RESET = 2'd3
  } hw_state_e;

  typedef struct packed {
    logic core;
    logic osc;
    logic tmr;
    logic wdog;
    logic hflag;
    logic rstout;
  } hw_out_s;

  function automatic hw_out_s hw_decode(hw_state_e s);
    hw_out_s o;
    o = '0;
    case (s)
      ST_RUN: begin
        o.core = 1'b1;
        o.osc  = 1'b1;
        o.tmr  = 1'b1;
        o.wdog = 1'b1;
      end
      ST_HALT: begin
        o.hflag = 1'b1;
      end
      ST_OSC: begin
        o.osc   = 1'b1;
        o.hflag = 1'b1;
      end
      default: begin
        o.osc    = 1'b1;
        o.rstout = 1'b1;
      end
    endcase
    return o;
  endfunction

endpackage

// File: rtl/hw_sync.sv
module hw_sync #(
  parameter int          W       = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= {W{RST_VAL}};
      q      <= {W{RST_VAL}};
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/hw_wake_edge.sv
module hw_wake_edge #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] en,
  output logic         evt
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) prev_q[gi] <= 1'b0;
        else     prev_q[gi] <= lvl[gi];
      end
      assign hit[gi] = lvl[gi] & ~prev_q[gi] & en[gi];
    end
  endgenerate

  assign evt = |hit;
endmodule

// File: rtl/hw_tick_div.sv
module hw_tick_div #(
  parameter int DIV = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/hw_stab_timer.sv
module hw_stab_timer #(
  parameter int COUNT = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  output logic expire
);
  localparam int TW = $clog2(COUNT + 1);
  localparam logic [TW-1:0] INIT = TW'(COUNT);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= '0;
    else if (load)              cnt_q <= INIT;
    else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire = tick && (cnt_q == TW'(1));
endmodule

// File: rtl/halt_wake_seq.sv
module halt_wake_seq
  import halt_wake_pkg::*;
#(
  parameter int WAKE_W     = 4,
  parameter int STAB_COUNT = 256,
  parameter int OSC_DIV    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_set,
  input  logic              ext_rst_n,
  input  logic              clkmon_en,
  input  logic [WAKE_W-1:0] wake_en,
  input  logic [WAKE_W-1:0] wake_in,
  output logic              core_clk_en,
  output logic              osc_en,
  output logic              timer_en,
  output logic              wdog_en,
  output logic              wdout_low,
  output logic              halt_flag,
  output logic              reset_out,
  output logic              resume_pulse
);
  hw_state_e   st_q, st_nxt;
  hw_out_s     dec;
  logic        pin_rst_n;
  logic [WAKE_W-1:0] wake_s;
  logic        wake_evt;
  logic        stab_load;
  logic        div_tick;
  logic        stab_done;

  hw_sync #(.W(1), .RST_VAL(1'b1)) u_rst_sync (
    .clk(clk), .rst(rst), .d(ext_rst_n), .q(pin_rst_n)
  );

  hw_sync #(.W(WAKE_W), .RST_VAL(1'b0)) u_wake_sync (
    .clk(clk), .rst(rst), .d(wake_in), .q(wake_s)
  );

  hw_wake_edge #(.W(WAKE_W)) u_edge (
    .clk(clk), .rst(rst), .lvl(wake_s), .en(wake_en), .evt(wake_evt)
  );

  hw_tick_div #(.DIV(OSC_DIV)) u_div (
    .clk(clk), .rst(rst), .run(st_q == ST_OSC), .tick(div_tick)
  );

  hw_stab_timer #(.COUNT(STAB_COUNT)) u_stab (
    .clk(clk), .rst(rst), .load(stab_load), .tick(div_tick), .expire(stab_done)
  );

  // next state: external reset has priority in every state
  always_comb begin
    st_nxt = st_q;
    case (st_q)
      ST_RUN:   if (!pin_rst_n) st_nxt = ST_RESET;
                else if (halt_set) st_nxt = ST_HALT;
      ST_HALT:  if (!pin_rst_n) st_nxt = ST_RESET;
                else if (wake_evt) st_nxt = ST_OSC;
      ST_OSC:   if (!pin_rst_n) st_nxt = ST_RESET;
                else if (stab_done) st_nxt = ST_RUN;
      default:  if (pin_rst_n) st_nxt = ST_RUN;
    endcase
  end

  assign stab_load = (st_q == ST_HALT) && (st_nxt == ST_OSC);
  assign dec       = hw_decode(st_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_RUN;
      core_clk_en  <= 1'b1;
      osc_en       <= 1'b1;
      timer_en     <= 1'b1;
      wdog_en      <= 1'b1;
      halt_flag    <= 1'b0;
      reset_out    <= 1'b0;
      wdout_low    <= 1'b0;
      resume_pulse <= 1'b0;
    end else begin
      st_q         <= st_nxt;
      core_clk_en  <= dec.core;
      osc_en       <= dec.osc;
      timer_en     <= dec.tmr;
      wdog_en      <= dec.wdog;
      halt_flag    <= dec.hflag;
      reset_out    <= dec.rstout;
      wdout_low    <= clkmon_en && (st_nxt == ST_HALT);
      resume_pulse <= (st_q == ST_OSC) && (st_nxt == ST_RUN);
    end
  end
endmodule

// File: rtl/halt_wake_seq_chk.sv
module halt_wake_seq_chk #(
  parameter int STAB_COUNT = 256,
  parameter int OSC_DIV    = 9
) (
  input logic clk,
  input logic rst,
  input logic core_clk_en,
  input logic osc_en,
  input logic timer_en,
  input logic wdog_en,
  input logic wdout_low,
  input logic halt_flag,
  input logic reset_out,
  input logic resume_pulse
);
  int unsigned osc_cyc_q;

  // counts cycles spent with the oscillator restarted but the core halted
  always_ff @(posedge clk) begin
    if (rst) osc_cyc_q <= 0;
    else if (halt_flag && osc_en) osc_cyc_q <= osc_cyc_q + 1;
    else osc_cyc_q <= 0;
  end

  assert_halt_gates_R2: assert property (@(posedge clk) disable iff (rst)
    halt_flag |-> (!core_clk_en && !timer_en && !wdog_en));

  assert_monitor_only_halted_R3: assert property (@(posedge clk) disable iff (rst)
    wdout_low |-> (halt_flag && !osc_en));

  assert_wake_core_off_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(osc_en) && halt_flag) |-> !core_clk_en);

  assert_stab_length_R5: assert property (@(posedge clk) disable iff (rst)
    resume_pulse |-> (osc_cyc_q == STAB_COUNT * OSC_DIV));

  assert_resume_single_R5: assert property (@(posedge clk) disable iff (rst)
    resume_pulse |=> !resume_pulse);

  assert_reset_shape_R7: assert property (@(posedge clk) disable iff (rst)
    reset_out |-> (!core_clk_en && osc_en && !halt_flag && !resume_pulse));

  assert_no_resume_after_reset_R8: assert property (@(posedge clk) disable iff (rst)
    $past(reset_out) |-> !resume_pulse);
endmodule

bind halt_wake_seq halt_wake_seq_chk #(
  .STAB_COUNT(STAB_COUNT),
  .OSC_DIV(OSC_DIV)
) u_chk (
  .clk(clk), .rst(rst),
  .core_clk_en(core_clk_en), .osc_en(osc_en), .timer_en(timer_en),
  .wdog_en(wdog_en), .wdout_low(wdout_low), .halt_flag(halt_flag),
  .reset_out(reset_out), .resume_pulse(resume_pulse)
);

// File: tb/halt_wake_seq_tb.sv
module halt_wake_seq_tb;
  localparam int W     = 4;
  localparam int STAB  = 256;
  localparam int DIV   = 9;
  localparam int DELAY = STAB * DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_set = 1'b0;
  logic ext_rst_n = 1'b1;
  logic clkmon_en = 1'b1;
  logic [W-1:0] wake_en = '0;
  logic [W-1:0] wake_in = '0;
  logic core_clk_en, osc_en, timer_en, wdog_en, wdout_low;
  logic halt_flag, reset_out, resume_pulse;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  halt_wake_seq #(.WAKE_W(W), .STAB_COUNT(STAB), .OSC_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .halt_set(halt_set), .ext_rst_n(ext_rst_n),
    .clkmon_en(clkmon_en), .wake_en(wake_en), .wake_in(wake_in),
    .core_clk_en(core_clk_en), .osc_en(osc_en), .timer_en(timer_en),
    .wdog_en(wdog_en), .wdout_low(wdout_low), .halt_flag(halt_flag),
    .reset_out(reset_out), .resume_pulse(resume_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: every resume pulse must match a queued expected cycle
  always @(negedge clk) begin
    if (!rst && resume_pulse) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected resume", cyc, -1);
      end else begin
        check("R5 resume cycle", cyc, exp_q.pop_front());
        check("R5 core back on", int'(core_clk_en), 1);
        check("R5 flag cleared", int'(halt_flag), 0);
      end
    end
  end

  task automatic do_halt();
    halt_set = 1'b1;
    wait_cyc(1);
    halt_set = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int c;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    // R1 reset state
    check("R1 core", int'(core_clk_en), 1);
    check("R1 osc", int'(osc_en), 1);
    check("R1 wdog/timer", int'(wdog_en & timer_en), 1);
    check("R1 flags", int'({halt_flag, reset_out, resume_pulse, wdout_low}), 0);

    // R2 / R3 halt entry with clock monitor on
    do_halt();
    check("R2 core off", int'(core_clk_en), 0);
    check("R2 osc/timer/wdog off", int'({osc_en, timer_en, wdog_en}), 0);
    check("R2 halt flag", int'(halt_flag), 1);
    check("R3 wdout low", int'(wdout_low), 1);

    // R6 masked wake input
    wake_en = 4'b0001;
    wake_in[2] = 1'b1;
    wait_cyc(20);
    check("R6 masked wake ignored", int'(osc_en), 0);
    wake_in[2] = 1'b0;

    // R4 / R5 wake-up
    c = cyc;
    wake_in[0] = 1'b1;
    exp_q.push_back(c + 3 + DELAY);
    wait_cyc(2);
    check("R4 osc not yet", int'(osc_en), 0);
    wait_cyc(1);
    check("R4 osc on", int'(osc_en), 1);
    check("R4 core still off", int'(core_clk_en), 0);
    check("R3 wdout released", int'(wdout_low), 0);
    wait_cyc(100);
    do_halt(); // R9 halt write during delay must not restart it
    wait_cyc(DELAY);
    check("R5 running", int'(core_clk_en), 1);
    check("R9 queue drained", exp_q.size(), 0);

    // R6 wake edge while running is forgotten
    wake_in[0] = 1'b0;
    wait_cyc(5);
    wake_in[0] = 1'b1;
    wait_cyc(5);
    check("R6 run wake ignored", int'(core_clk_en), 1);
    do_halt();
    wait_cyc(50);
    check("R6 no stale wake", int'(osc_en), 0);

    // R8 reset during the stabilisation delay
    wake_in[0] = 1'b0;
    wait_cyc(3);
    wake_in[0] = 1'b1;
    wait_cyc(1000);
    check("R8 in delay", int'(osc_en & halt_flag), 1);
    c = cyc;
    ext_rst_n = 1'b0;
    wait_cyc(2);
    check("R7 reset latency", int'(reset_out), 0);
    wait_cyc(1);
    check("R8 reset wins", int'(reset_out), 1);
    check("R7 core off osc on", int'({core_clk_en, osc_en}), 1);
    check("R7 flag cleared", int'(halt_flag), 0);
    halt_set = 1'b1; // R9 ignored in reset
    wait_cyc(5);
    halt_set = 1'b0;
    ext_rst_n = 1'b1;
    wait_cyc(3);
    check("R7 released", int'({core_clk_en, reset_out}), 2);
    check("R9 no halt after reset", int'(halt_flag), 0);
    wait_cyc(DELAY + 50);
    check("R8 no late resume", int'(core_clk_en), 1);

    // R3 / R7 reset from halt with clock monitor off
    clkmon_en = 1'b0;
    do_halt();
    check("R3 monitor off", int'(wdout_low), 0);
    ext_rst_n = 1'b0;
    wait_cyc(3);
    check("R7 reset from halt", int'(reset_out), 1);
    ext_rst_n = 1'b1;
    wait_cyc(3);
    check("R7 run after halt reset", int'(core_clk_en), 1);

    // R4 / R5 second wake on another input
    wake_en = 4'b1000;
    do_halt();
    c = cyc;
    wake_in[3] = 1'b1;
    exp_q.push_back(c + 3 + DELAY);
    wait_cyc(DELAY + 10);
    check("R5 second resume", int'(core_clk_en & ~halt_flag), 1);
    check("R5 all resumes seen", exp_q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule